// File: doc/BRIEF.md
# Double-Buffered Configuration Register Bank

This block keeps a bank of byte-wide configuration registers for a power-management chip. Every register is a pair of storage stages. The front stage is what the bus writes and reads back. The back stage drives the function outputs. An update-control register sets how a bus write reaches the back stage. In pass-through mode it reaches both stages at once. In staged mode it stays in the front stage until a commit command copies every front stage into its back stage on the same clock edge. That makes a multi-register reconfiguration atomic.

After reset, and again whenever software asks for a reload, a sequencer fetches one byte per register from a nonvolatile read port. It uses a request/valid handshake with any latency. The bytes fill the front stages in index order, and one global commit then moves them to the outputs. The bank answers every bus request with a negative response until that commit. A one-cycle ready pulse follows a programmable number of cycles later. The update-control register also exports an erase-enable flag for the nonvolatile controller.

Top module: `dbl_cfg_bank`

## Requirements
- R1: From reset, `busy` is 1. The sequencer reads every register index 0..NREG-1 and then commits once. After `busy` falls, `cfg_out` and the bus readback of each register equal the stored byte for that index.
- R2: The nonvolatile address for register index N is NV_BASE+N. `nv_req` is a one-cycle pulse, and the next request is issued only after `nv_rvalid` has returned the previous byte, whatever the latency.
- R3: With update-control bit 0 = 0, a bus write to a register changes its readback value but leaves `cfg_out` unchanged.
- R4: Writing update-control with bit 1 = 1 copies every front stage into its back stage on the edge that accepts the write. Bit 1 always reads back as 0.
- R5: With update-control bit 0 = 1, a bus write to a register changes both its readback and its `cfg_out` byte on the accepting edge.
- R6: `erase_en` equals update-control bit 2, and the bit reads back at position 2.
- R7: While `busy` is 1, every request gets `bus_nack` = 1 and `bus_ack` = 0 one cycle later, and has no effect on any register.
- R8: A write to the download register with bit 0 = 1 starts a full reload (R1, R2) that restores the stored bytes over any edits. With bit 0 = 0 it does nothing. It always reads back as 0.
- R9: `cfg_ready` is high for exactly one cycle, DONE_DLY-1 cycles after the first cycle in which `busy` is 0 at the end of a reload.
- R10: A request to an address at or above NREG that is not a control address is acknowledged. A write there is ignored, and a read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req | input | 1 | Bus request, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Register or control address |
| bus_wdata | input | DW | Write data |
| bus_ack | output | 1 | Access accepted, one cycle after the request |
| bus_nack | output | 1 | Access refused while busy |
| bus_rdata | output | DW | Read data, valid with `bus_ack` |
| nv_req | output | 1 | Nonvolatile read request pulse |
| nv_addr | output | NV_AW | Nonvolatile byte address |
| nv_rvalid | input | 1 | Nonvolatile read data valid |
| nv_rdata | input | DW | Nonvolatile read data |
| busy | output | 1 | Reload in progress |
| cfg_ready | output | 1 | Delayed completion pulse |
| erase_en | output | 1 | Erase-enable flag for the nonvolatile controller |
| cfg_out | output | NREG*DW | Back-stage values, register i at bits i*DW +: DW |

## Verification
The bench builds the bank with NREG = 16 and DONE_DLY = 5. A whole reload then takes about a hundred cycles, so the test can run several reloads, including a software-triggered one in the middle. The short completion delay lets the bench count the exact distance from the fall of `busy` to the ready pulse. The nonvolatile model answers each request after a random latency of one to four cycles, which tests the handshake rather than a fixed timing. Addresses from 16 upward bring the out-of-range behaviour within reach of random traffic.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

  typedef enum logic [2:0] {
    LD_IDLE   = 3'd0,
    LD_REQ    = 3'd1,
    LD_WAIT   = 3'd2,
    LD_COMMIT = 3'd3,
    LD_DELAY  = 3'd4
  } ld_state_e;

  // update-control bit positions
  localparam int UPD_TRANS_BIT  = 0;
  localparam int UPD_COMMIT_BIT = 1;
  localparam int UPD_ERASE_BIT  = 2;
  localparam int DL_GO_BIT      = 0;

endpackage

// File: rtl/cfgbank_cell.sv
module cfgbank_cell #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_we,
  input  logic          b_we,
  input  logic [DW-1:0] wdata,
  input  logic          commit,
  output logic [DW-1:0] a_q,
  output logic [DW-1:0] b_q
);

  logic [DW-1:0] a_d, b_d;
  logic          a_en, b_en;

  always_comb begin
    a_en = a_we;
    a_d  = wdata;
    b_en = commit | b_we;
    b_d  = commit ? a_q : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (a_en) a_q <= a_d;
      if (b_en) b_q <= b_d;
    end
  end

  AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!commit && !b_we) |=> $stable(b_q)); // R3

endmodule

// File: rtl/cfgbank_reload.sv
module cfgbank_reload
  import cfgbank_pkg::*;
#(
  parameter int                NREG     = 224,
  parameter int                DW       = 8,
  parameter int                NV_AW    = 16,
  parameter logic [NV_AW-1:0]  NV_BASE  = 16'hF800,
  parameter int                DONE_DLY = 50000,
  parameter int                IDXW     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             nv_req,
  output logic [NV_AW-1:0] nv_addr,
  input  logic             nv_rvalid,
  input  logic [DW-1:0]    nv_rdata,
  output logic             ld_we,
  output logic [IDXW-1:0]  ld_idx,
  output logic [DW-1:0]    ld_data,
  output logic             commit,
  output logic             busy,
  output logic             ready
);

  localparam int               DLYW = $clog2(DONE_DLY + 1);
  localparam logic [IDXW-1:0]  LAST = IDXW'(NREG - 1);
  localparam logic [DLYW-1:0]  DLY0 = DLYW'(DONE_DLY - 1);

  ld_state_e       state_q, state_d;
  logic [IDXW-1:0] idx_q, idx_d;
  logic [DLYW-1:0] cnt_q, cnt_d;
  logic            boot_q;
  logic            go;

  assign go = boot_q | start;

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    cnt_d   = cnt_q;
    nv_req  = 1'b0;
    ld_we   = 1'b0;
    commit  = 1'b0;
    ready   = 1'b0;
    case (state_q)
      LD_IDLE: begin
        if (go) begin
          state_d = LD_REQ;
          idx_d   = '0;
        end
      end
      LD_REQ: begin
        nv_req  = 1'b1;
        state_d = LD_WAIT;
      end
      LD_WAIT: begin
        if (nv_rvalid) begin
          ld_we = 1'b1;
          if (idx_q == LAST) begin
            state_d = LD_COMMIT;
          end else begin
            idx_d   = idx_q + 1'b1;
            state_d = LD_REQ;
          end
        end
      end
      LD_COMMIT: begin
        commit  = 1'b1;
        cnt_d   = DLY0;
        state_d = LD_DELAY;
      end
      LD_DELAY: begin
        if (go) begin
          state_d = LD_REQ;
          idx_d   = '0;
        end else if (cnt_q == '0) begin
          ready   = 1'b1;
          state_d = LD_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: state_d = LD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LD_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      boot_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      boot_q  <= 1'b0;
    end
  end

  assign busy    = boot_q | (state_q == LD_REQ) | (state_q == LD_WAIT) | (state_q == LD_COMMIT);
  assign nv_addr = NV_BASE + NV_AW'(idx_q);
  assign ld_idx  = idx_q;
  assign ld_data = nv_rdata;

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req |=> !nv_req); // R2
  AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    nv_req |-> busy); // R1
  AST_READY_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !busy); // R9
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready); // R9

endmodule

// File: rtl/cfgbank_ctrl.sv
module cfgbank_ctrl
  import cfgbank_pkg::*;
#(
  parameter int             AW       = 8,
  parameter int             DW       = 8,
  parameter int             NREG     = 224,
  parameter logic [AW-1:0]  UPD_ADDR = 8'h90,
  parameter logic [AW-1:0]  DL_ADDR  = 8'hD8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_req,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          busy,
  input  logic [DW-1:0] bank_rd,
  output logic          bus_ack,
  output logic          bus_nack,
  output logic [DW-1:0] bus_rdata,
  output logic          transparent,
  output logic          erase_en,
  output logic          commit_req,
  output logic          dl_start,
  output logic          bank_we
);

  logic          take, hit_upd, hit_dl, in_bank;
  logic          trans_q, trans_d, erase_q, erase_d;
  logic          ack_d, nack_d;
  logic [DW-1:0] rdata_q, rdata_d, upd_view;
  logic          rdata_en;

  always_comb begin
    take     = bus_req & ~busy;
    hit_upd  = (bus_addr == UPD_ADDR);
    hit_dl   = (bus_addr == DL_ADDR);
    in_bank  = (int'(bus_addr) < NREG) & ~hit_upd & ~hit_dl;
    upd_view = '0;
    upd_view[UPD_TRANS_BIT] = trans_q;
    upd_view[UPD_ERASE_BIT] = erase_q;

    trans_d = trans_q;
    erase_d = erase_q;
    if (take && bus_we && hit_upd) begin
      trans_d = bus_wdata[UPD_TRANS_BIT];
      erase_d = bus_wdata[UPD_ERASE_BIT];
    end

    commit_req = take & bus_we & hit_upd & bus_wdata[UPD_COMMIT_BIT];
    dl_start   = take & bus_we & hit_dl & bus_wdata[DL_GO_BIT];
    bank_we    = take & bus_we & in_bank;

    ack_d    = take;
    nack_d   = bus_req & busy;
    rdata_en = take & ~bus_we;
    if (hit_upd)      rdata_d = upd_view;
    else if (in_bank) rdata_d = bank_rd;
    else              rdata_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trans_q  <= 1'b0;
      erase_q  <= 1'b0;
      bus_ack  <= 1'b0;
      bus_nack <= 1'b0;
      rdata_q  <= '0;
    end else begin
      trans_q  <= trans_d;
      erase_q  <= erase_d;
      bus_ack  <= ack_d;
      bus_nack <= nack_d;
      if (rdata_en) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata   = rdata_q;
  assign transparent = trans_q;
  assign erase_en    = erase_q;

  AST_NACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && busy) |=> (bus_nack && !bus_ack)); // R7
  AST_RESP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bus_ack, bus_nack})); // R7
  AST_ERASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_we && !busy && hit_upd) |=> $stable(erase_en)); // R6

endmodule

// File: rtl/dbl_cfg_bank.sv
module dbl_cfg_bank #(
  parameter int                NREG     = 224,
  parameter int                AW       = 8,
  parameter int                DW       = 8,
  parameter int                NV_AW    = 16,
  parameter logic [NV_AW-1:0]  NV_BASE  = 16'hF800,
  parameter logic [AW-1:0]     UPD_ADDR = 8'h90,
  parameter logic [AW-1:0]     DL_ADDR  = 8'hD8,
  parameter int                DONE_DLY = 50000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req,
  input  logic               bus_we,
  input  logic [AW-1:0]      bus_addr,
  input  logic [DW-1:0]      bus_wdata,
  output logic               bus_ack,
  output logic               bus_nack,
  output logic [DW-1:0]      bus_rdata,
  output logic               nv_req,
  output logic [NV_AW-1:0]   nv_addr,
  input  logic               nv_rvalid,
  input  logic [DW-1:0]      nv_rdata,
  output logic               busy,
  output logic               cfg_ready,
  output logic               erase_en,
  output logic [NREG*DW-1:0] cfg_out
);

  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

  // asynchronous assert, synchronous release
  logic rst_meta, rst_sync;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  logic            transparent, commit_req, dl_start, bank_we;
  logic            ld_we, ld_commit, commit_all;
  logic [IDXW-1:0] ld_idx;
  logic [DW-1:0]   ld_data, bank_rd;
  logic [DW-1:0]   a_arr [NREG];
  logic [DW-1:0]   b_arr [NREG];
  logic [NREG*DW-1:0] a_flat;

  cfgbank_ctrl #(
    .AW(AW), .DW(DW), .NREG(NREG), .UPD_ADDR(UPD_ADDR), .DL_ADDR(DL_ADDR)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_sync),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .busy(busy), .bank_rd(bank_rd),
    .bus_ack(bus_ack), .bus_nack(bus_nack), .bus_rdata(bus_rdata),
    .transparent(transparent), .erase_en(erase_en),
    .commit_req(commit_req), .dl_start(dl_start), .bank_we(bank_we)
  );

  cfgbank_reload #(
    .NREG(NREG), .DW(DW), .NV_AW(NV_AW), .NV_BASE(NV_BASE),
    .DONE_DLY(DONE_DLY), .IDXW(IDXW)
  ) reload_i (
    .clk(clk), .rst_n(rst_sync), .start(dl_start),
    .nv_req(nv_req), .nv_addr(nv_addr), .nv_rvalid(nv_rvalid), .nv_rdata(nv_rdata),
    .ld_we(ld_we), .ld_idx(ld_idx), .ld_data(ld_data),
    .commit(ld_commit), .busy(busy), .ready(cfg_ready)
  );

  assign commit_all = commit_req | ld_commit;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic bus_sel, ld_sel, a_we_i, b_we_i;
    logic [DW-1:0] wdata_i;
    assign bus_sel = bank_we & (int'(bus_addr) == i);
    assign ld_sel  = ld_we & (ld_idx == IDXW'(i));
    assign a_we_i  = bus_sel | ld_sel;
    assign b_we_i  = bus_sel & transparent;
    assign wdata_i = ld_sel ? ld_data : bus_wdata;

    cfgbank_cell #(.DW(DW)) cell_i (
      .clk(clk), .rst_n(rst_sync),
      .a_we(a_we_i), .b_we(b_we_i), .wdata(wdata_i), .commit(commit_all),
      .a_q(a_arr[i]), .b_q(b_arr[i])
    );

    assign cfg_out[i*DW +: DW] = b_arr[i];
    assign a_flat[i*DW +: DW]  = a_arr[i];
  end

  always_comb begin
    bank_rd = '0;
    for (int i = 0; i < NREG; i++) begin
      if (int'(bus_addr) == i) bank_rd = a_arr[i];
    end
  end

  AST_COMMIT_ATOMIC: assert property (@(posedge clk) disable iff (!rst_sync)
    commit_all |=> (cfg_out == $past(a_flat))); // R4
  AST_STAGED_HOLD: assert property (@(posedge clk) disable iff (!rst_sync)
    (bank_we && !transparent) |=> $stable(cfg_out)); // R3
  AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_sync)
    busy |-> !bank_we); // R7

endmodule

// File: tb/dbl_cfg_bank_tb_top.sv
module dbl_cfg_bank_tb_top;

  localparam int              NREG     = 16;
  localparam int              NW       = NREG * 8;
  localparam logic [15:0]     NV_BASE  = 16'hF800;
  localparam logic [7:0]      UPD_ADDR = 8'h90;
  localparam logic [7:0]      DL_ADDR  = 8'hD8;
  localparam int              DONE_DLY = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          bus_req, bus_we;
  logic [7:0]    bus_addr, bus_wdata, bus_rdata;
  logic          bus_ack, bus_nack;
  logic          nv_req, nv_rvalid;
  logic [15:0]   nv_addr;
  logic [7:0]    nv_rdata;
  logic          busy, cfg_ready, erase_en;
  logic [NW-1:0] cfg_out;

  always #5 clk = ~clk;

  dbl_cfg_bank #(
    .NREG(NREG), .NV_BASE(NV_BASE), .UPD_ADDR(UPD_ADDR), .DL_ADDR(DL_ADDR), .DONE_DLY(DONE_DLY)
  ) dut_i (
    .clk(clk), .rst_n(rst_n),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_ack(bus_ack), .bus_nack(bus_nack), .bus_rdata(bus_rdata),
    .nv_req(nv_req), .nv_addr(nv_addr), .nv_rvalid(nv_rvalid), .nv_rdata(nv_rdata),
    .busy(busy), .cfg_ready(cfg_ready), .erase_en(erase_en), .cfg_out(cfg_out)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_a [NREG];
  logic [7:0] exp_b [NREG];
  bit m_trans, m_erase;
  int nv_count = 0;

  function automatic logic [7:0] nv_val(input logic [15:0] a);
    return (a[7:0] * 8'd37) ^ 8'hA5;
  endfunction

  function automatic logic [NW-1:0] exp_vec();
    logic [NW-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = exp_b[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == UPD_ADDR) return {5'b0, m_erase, 1'b0, m_trans};
    if (a == DL_ADDR) return 8'h00;
    if (int'(a) < NREG) return exp_a[a[3:0]];
    return 8'h00;
  endfunction

  task automatic chk(input string tag, input logic [NW-1:0] act, input logic [NW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // nonvolatile read port model, random latency 1..4 cycles
  initial begin
    nv_rvalid = 1'b0;
    nv_rdata  = '0;
    forever begin
      if (nv_req === 1'b1) begin
        chk("R2 nv_addr", NW'(nv_addr), NW'(NV_BASE + 16'(nv_count % NREG)));
        nv_count++;
        repeat ($urandom_range(1, 4)) @(negedge clk);
        chk("R2 no request while waiting", NW'(nv_req), '0);
        nv_rdata  = nv_val(nv_addr);
        nv_rvalid = 1'b1;
        @(negedge clk);
        nv_rvalid = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
  end

  task automatic bus_op(input logic we, input logic [7:0] a, input logic [7:0] d,
                        output logic ack, output logic nack, output logic [7:0] rd);
    @(negedge clk);
    bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_req = 1'b0;
    ack = bus_ack; nack = bus_nack; rd = bus_rdata;
  endtask

  task automatic do_op(input string tag, input logic we, input logic [7:0] a, input logic [7:0] d);
    logic ack, nack;
    logic [7:0] rd;
    bus_op(we, a, d, ack, nack, rd);
    chk({tag, " R7 ack"}, NW'({ack, nack}), NW'(2'b10));
    if (!we) chk({tag, " readback"}, NW'(rd), NW'(exp_read(a)));
    else if (a == UPD_ADDR) begin
      m_trans = d[0];
      m_erase = d[2];
      if (d[1]) for (int i = 0; i < NREG; i++) exp_b[i] = exp_a[i];
    end else if (int'(a) < NREG) begin
      exp_a[a[3:0]] = d;
      if (m_trans) exp_b[a[3:0]] = d;
    end
    chk({tag, " cfg_out"}, cfg_out, exp_vec());
    chk({tag, " R6 erase_en"}, NW'(erase_en), NW'(m_erase));
  endtask

  task automatic wait_reload();
    int n;
    n = 0;
    while (busy === 1'b1) @(negedge clk);
    while (cfg_ready !== 1'b1 && n < 50) begin
      @(negedge clk);
      n++;
    end
    chk("R9 ready delay", NW'(n), NW'(DONE_DLY - 1));
    @(negedge clk);
    chk("R9 ready single cycle", NW'(cfg_ready), '0);
    for (int i = 0; i < NREG; i++) begin
      exp_a[i] = nv_val(NV_BASE + 16'(i));
      exp_b[i] = exp_a[i];
    end
    chk("R1 cfg_out after reload", cfg_out, exp_vec());
    for (int i = 0; i < NREG; i++) do_op("R1 read reloaded", 1'b0, 8'(i), 8'h00);
  endtask

  initial begin
    logic ack, nack;
    logic [7:0] rd;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; bus_req = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_trans = 0; m_erase = 0;
    repeat (4) @(negedge clk);
    chk("R1 busy in reset", NW'(busy), NW'(1));
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy after reset", NW'(busy), NW'(1));
    bus_op(1'b1, UPD_ADDR, 8'h05, ack, nack, rd);
    chk("R7 nack while busy", NW'({ack, nack}), NW'(2'b01));
    wait_reload();
    do_op("R7 ignored write", 1'b0, UPD_ADDR, 8'h00);

    // staged writes
    do_op("R3 staged write", 1'b1, 8'd3, 8'h3C);
    do_op("R3 staged write", 1'b1, 8'd7, 8'hC3);
    do_op("R3 staged read", 1'b0, 8'd3, 8'h00);
    // commit
    do_op("R4 commit", 1'b1, UPD_ADDR, 8'h02);
    do_op("R4 bit1 reads 0", 1'b0, UPD_ADDR, 8'h00);
    // transparent
    do_op("R5 set transparent", 1'b1, UPD_ADDR, 8'h01);
    do_op("R5 transparent write", 1'b1, 8'd5, 8'h99);
    do_op("R5 transparent read", 1'b0, 8'd5, 8'h00);
    // erase enable
    do_op("R6 erase on", 1'b1, UPD_ADDR, 8'h04);
    do_op("R6 erase read", 1'b0, UPD_ADDR, 8'h00);
    do_op("R3 staged last reg", 1'b1, 8'(NREG - 1), 8'h11);
    // out of range
    do_op("R10 write out of range", 1'b1, 8'd20, 8'hEE);
    do_op("R10 read out of range", 1'b0, 8'd20, 8'h00);
    do_op("R10 read high addr", 1'b0, 8'hF0, 8'h00);

    // random traffic
    for (int k = 0; k < 80; k++) begin
      int r;
      r = $urandom_range(0, 9);
      case (r)
        0, 1, 2, 3, 4: do_op("R3/R5 rand write", 1'b1, 8'($urandom_range(0, NREG - 1)), 8'($urandom));
        5, 6:          do_op("R3 rand read", 1'b0, 8'($urandom_range(0, NREG - 1)), 8'h00);
        7:             do_op("R4/R6 rand ctrl", 1'b1, UPD_ADDR, 8'($urandom_range(0, 7)));
        8:             do_op("R6 rand ctrl read", 1'b0, UPD_ADDR, 8'h00);
        default:       do_op("R10 rand oor", 1'($urandom_range(0, 1)), 8'($urandom_range(16, 127)), 8'($urandom));
      endcase
    end

    // download with bit0 = 0 does nothing
    do_op("R8 download bit0 clear", 1'b1, DL_ADDR, 8'hFE);
    chk("R8 no reload", NW'(busy), '0);
    do_op("R8 download reads 0", 1'b0, DL_ADDR, 8'h00);

    // edits then user download restores stored bytes
    do_op("R8 edit", 1'b1, UPD_ADDR, 8'h00);
    do_op("R8 edit", 1'b1, 8'd0, 8'h12);
    do_op("R8 edit", 1'b1, 8'd9, 8'h34);
    do_op("R8 edit commit", 1'b1, UPD_ADDR, 8'h02);
    nv_count = 0;
    do_op("R8 download go", 1'b1, DL_ADDR, 8'h01);
    chk("R8 busy after go", NW'(busy), NW'(1));
    bus_op(1'b1, 8'd0, 8'h77, ack, nack, rd);
    chk("R7 nack during user reload", NW'({ack, nack}), NW'(2'b01));
    wait_reload();
    chk("R2 request count", NW'(nv_count), NW'(NREG));

    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
    $finish;
  end

endmodule